// File: doc/BRIEF.md
# Acknowledge-History Priority Mapper

This block produces the request priority of one bus master channel for the arbiter in front of a memory controller. Each cycle the channel requests, one bit describing the outcome (granted or not granted, depending on a polarity select) enters a short history register. The block counts the ones among the newest N bits, where N is programmable. It then uses that count to index a sixteen-entry table of 4-bit priorities. The table can be filled so that a channel loses priority as its bus use grows, or so that a waiting channel gains priority over time.

Two tables are supplied: a main one and an alternate one. A mode bit picks the rule that swaps in the alternate table. Under the first rule the swap follows a congestion flag from the controller. Under the second it follows the incoming priority of the display-class requester. On the display channel, an override path can replace the mapped value with that incoming priority. The result is held in a single output register.

Top module: `ack_prio_mapper`

## Requirements
- R1: The history changes only on cycles with `req_i` high. On such a cycle it shifts by one, and the bit that enters at position 0 is `ack_i XOR ack_inv_i`. With `req_i` low, the output does not move in response to `ack_i`.
- R2: The count is the number of ones in history bits 0 through `len_sel_i` inclusive. Bit 0 is the newest, so `len_sel_i` = L looks at the L+1 newest outcomes.
- R3: The count saturates at 15. Sixteen ones in view give the same result as fifteen.
- R4: The mapped priority is entry k of the selected table, where k is the count. Entry k occupies bits [4k+3:4k] of the 64-bit table input.
- R5: With `tbl_mode_i` = 1, the alternate table is used while `cong_i` = 1, and the main table otherwise.
- R6: With `tbl_mode_i` = 0, the alternate table is used while `disp_prio_i` > 8. A value of exactly 8 uses the main table.
- R7: `prio_o` is registered. After a clock edge it shows the value computed from the inputs and history present before that edge, so table, select and override changes appear one cycle later, and a new history bit appears two cycles later.
- R8: On the display variant, `bypass_en_i` = 1 makes `prio_o` equal to `disp_prio_i` one cycle later, regardless of history and tables.
- R9: Reset is synchronous and active high. It clears the history, and while it is held `prio_o` takes main-table entry 0, with the override ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Channel requesting this cycle |
| ack_i | input | 1 | Channel granted this cycle |
| ack_inv_i | input | 1 | 1: record non-grants instead of grants |
| len_sel_i | input | 4 | History window, newest `len_sel_i`+1 bits |
| tbl_mode_i | input | 1 | Alternate-table rule: 1 congestion, 0 display priority |
| cong_i | input | 1 | Controller congestion flag |
| disp_prio_i | input | 4 | Incoming display-class priority |
| bypass_en_i | input | 1 | Override mapped value with `disp_prio_i` |
| lut_main_i | input | 64 | Main table, sixteen 4-bit entries |
| lut_alt_i | input | 64 | Alternate table, sixteen 4-bit entries |
| prio_o | output | 4 | Registered channel priority |

## Verification
The bench builds the block with its defaults: a 16-bit history, 4-bit priorities and the display variant with the override path present. This is small enough that every window length from 1 to 16 can be swept under both polarities. Random request, grant, mode, congestion and display-priority patterns run against an arithmetic count-and-lookup model. The two tables are distinct permutations, so a wrong index or a wrong table shows up as a wrong value. Directed runs reach the saturation point of sixteen ones, the display threshold of 8 against 9, non-request cycles and every override value.

// File: rtl/prio_map_pkg.sv
package prio_map_pkg;

  typedef enum logic {
    TBL_MAIN = 1'b0,
    TBL_ALT  = 1'b1
  } tbl_sel_e;

  typedef enum logic {
    SWAP_ON_DISP = 1'b0,
    SWAP_ON_CONG = 1'b1
  } swap_rule_e;

endpackage

// File: rtl/ack_hist_count.sv
module ack_hist_count #(
  parameter int HIST_W = 16,
  parameter int PRIO_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_i,
  input  logic                      ack_i,
  input  logic                      ack_inv_i,
  input  logic [$clog2(HIST_W)-1:0] len_sel_i,
  output logic [PRIO_W-1:0]         cnt_o
);

  localparam int LEN_W = $clog2(HIST_W);
  localparam int SUM_W = $clog2(HIST_W + 1);
  localparam int MAXV  = (1 << PRIO_W) - 1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] win_mask;
  logic [HIST_W-1:0] seen;
  logic [SUM_W-1:0]  ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (req_i) begin
      hist_q <= {hist_q[HIST_W-2:0], ack_i ^ ack_inv_i};
    end
  end

  for (genvar g = 0; g < HIST_W; g++) begin : g_mask
    assign win_mask[g] = (LEN_W'(g) <= len_sel_i);
  end

  assign seen = hist_q & win_mask;

  always_comb begin
    ones = '0;
    for (int i = 0; i < HIST_W; i++) begin
      ones = ones + SUM_W'(seen[i]);
    end
  end

  assign cnt_o = (ones > SUM_W'(MAXV)) ? PRIO_W'(MAXV) : PRIO_W'(ones);

  // R1
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> $stable(hist_q));

  // R1
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> hist_q[0] == $past(ack_i ^ ack_inv_i));

  // R9
  hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> hist_q == '0);

endmodule

// File: rtl/tbl_choose.sv
module tbl_choose
  import prio_map_pkg::*;
#(
  parameter int PRIO_W      = 4,
  parameter int DISP_THRESH = 8
) (
  input  logic              tbl_mode_i,
  input  logic              cong_i,
  input  logic [PRIO_W-1:0] disp_prio_i,
  output tbl_sel_e          sel_o
);

  swap_rule_e rule;
  logic       disp_high;

  assign rule      = swap_rule_e'(tbl_mode_i);
  assign disp_high = (disp_prio_i > PRIO_W'(DISP_THRESH));

  always_comb begin
    unique case (rule)
      SWAP_ON_CONG: sel_o = cong_i    ? TBL_ALT : TBL_MAIN;
      SWAP_ON_DISP: sel_o = disp_high ? TBL_ALT : TBL_MAIN;
      default:      sel_o = TBL_MAIN;
    endcase
  end

endmodule

// File: rtl/lut_read.sv
module lut_read
  import prio_map_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic [(1<<PRIO_W)*PRIO_W-1:0] main_i,
  input  logic [(1<<PRIO_W)*PRIO_W-1:0] alt_i,
  input  tbl_sel_e                      sel_i,
  input  logic [PRIO_W-1:0]             idx_i,
  output logic [PRIO_W-1:0]             entry_o
);

  localparam int NENT = 1 << PRIO_W;

  logic [PRIO_W-1:0] main_e [NENT];
  logic [PRIO_W-1:0] alt_e  [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_split
    assign main_e[g] = main_i[g*PRIO_W +: PRIO_W];
    assign alt_e[g]  = alt_i[g*PRIO_W +: PRIO_W];
  end

  assign entry_o = (sel_i == TBL_ALT) ? alt_e[idx_i] : main_e[idx_i];

endmodule

// File: rtl/ack_prio_mapper.sv
module ack_prio_mapper
  import prio_map_pkg::*;
#(
  parameter int HIST_W      = 16,
  parameter int PRIO_W      = 4,
  parameter int DISP_THRESH = 8,
  parameter bit IS_DISPLAY  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_i,
  input  logic                          ack_i,
  input  logic                          ack_inv_i,
  input  logic [$clog2(HIST_W)-1:0]     len_sel_i,
  input  logic                          tbl_mode_i,
  input  logic                          cong_i,
  input  logic [PRIO_W-1:0]             disp_prio_i,
  input  logic                          bypass_en_i,
  input  logic [(1<<PRIO_W)*PRIO_W-1:0] lut_main_i,
  input  logic [(1<<PRIO_W)*PRIO_W-1:0] lut_alt_i,
  output logic [PRIO_W-1:0]             prio_o
);

  logic [PRIO_W-1:0] cnt;
  logic [PRIO_W-1:0] mapped;
  logic [PRIO_W-1:0] prio_d;
  logic [PRIO_W-1:0] prio_q;
  tbl_sel_e          sel;

  ack_hist_count #(.HIST_W(HIST_W), .PRIO_W(PRIO_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .ack_i     (ack_i),
    .ack_inv_i (ack_inv_i),
    .len_sel_i (len_sel_i),
    .cnt_o     (cnt)
  );

  tbl_choose #(.PRIO_W(PRIO_W), .DISP_THRESH(DISP_THRESH)) u_choose (
    .tbl_mode_i  (tbl_mode_i),
    .cong_i      (cong_i),
    .disp_prio_i (disp_prio_i),
    .sel_o       (sel)
  );

  lut_read #(.PRIO_W(PRIO_W)) u_lut (
    .main_i  (lut_main_i),
    .alt_i   (lut_alt_i),
    .sel_i   (sel),
    .idx_i   (cnt),
    .entry_o (mapped)
  );

  if (IS_DISPLAY) begin : g_bypass
    assign prio_d = bypass_en_i ? disp_prio_i : mapped;

    // R8
    bypass_out_chk: assert property (@(posedge clk) disable iff (rst)
      bypass_en_i |=> prio_o == $past(disp_prio_i));
  end else begin : g_plain
    assign prio_d = mapped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= lut_main_i[PRIO_W-1:0];
    end else begin
      prio_q <= prio_d;
    end
  end

  assign prio_o = prio_q;

  // R9
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> prio_o == $past(lut_main_i[PRIO_W-1:0]));

endmodule

// File: tb/sim_ack_prio_mapper.sv
module sim_ack_prio_mapper;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_i, ack_i, ack_inv_i;
  logic [3:0]  len_sel_i;
  logic        tbl_mode_i, cong_i, bypass_en_i;
  logic [3:0]  disp_prio_i;
  logic [63:0] lut_main_i, lut_alt_i;
  logic [3:0]  prio_o;

  int          checks = 0;
  int          fails  = 0;
  logic [15:0] hist_m;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_prio_mapper u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i), .ack_inv_i(ack_inv_i),
    .len_sel_i(len_sel_i), .tbl_mode_i(tbl_mode_i), .cong_i(cong_i),
    .disp_prio_i(disp_prio_i), .bypass_en_i(bypass_en_i),
    .lut_main_i(lut_main_i), .lut_alt_i(lut_alt_i), .prio_o(prio_o)
  );

  function automatic logic [3:0] model_out();
    int c = 0;
    logic alt;
    for (int i = 0; i <= int'(len_sel_i); i++) c += int'(hist_m[i]);
    if (c > 15) c = 15;
    alt = tbl_mode_i ? cong_i : (disp_prio_i > 4'd8);
    if (bypass_en_i) return disp_prio_i;
    return alt ? lut_alt_i[c*4 +: 4] : lut_main_i[c*4 +: 4];
  endfunction

  function automatic logic [15:0] next_lfsr(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: prio_o=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [3:0] e;
    e = model_out();
    if (req_i) hist_m = {hist_m[14:0], ack_i ^ ack_inv_i};
    @(posedge clk);
    @(negedge clk);
    check(tag, prio_o, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      lut_main_i[k*4 +: 4] = 4'((k * 5 + 2) % 16);
      lut_alt_i[k*4 +: 4]  = 4'(15 - k);
    end
    rst = 1'b1; req_i = 1'b1; ack_i = 1'b1; ack_inv_i = 1'b0;
    len_sel_i = 4'd15; tbl_mode_i = 1'b1; cong_i = 1'b1;
    disp_prio_i = 4'd5; bypass_en_i = 1'b1;
    hist_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset selects main entry 0 and ignores override
    check("R9", prio_o, lut_main_i[3:0]);
    rst = 1'b0; req_i = 1'b0; bypass_en_i = 1'b0; cong_i = 1'b0;
    step("R9");
    // R9: history empty after reset
    check("R9", prio_o, lut_main_i[3:0]);

    // R1 R2 R4 R5 R6 R7: sweep polarities and window lengths
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < 16; l++) begin
        ack_inv_i = 1'(p);
        len_sel_i = 4'(l);
        for (int s = 0; s < 24; s++) begin
          lfsr = next_lfsr(lfsr);
          req_i = lfsr[0] | lfsr[5];
          ack_i = lfsr[1] | lfsr[7];
          tbl_mode_i = lfsr[2];
          cong_i = lfsr[3];
          disp_prio_i = lfsr[11:8];
          step("R2_R4_R5_R6_R7 sweep");
        end
      end
    end

    // R3: sixteen ones saturate at entry 15
    tbl_mode_i = 1'b1; cong_i = 1'b0; ack_inv_i = 1'b0; len_sel_i = 4'd15;
    req_i = 1'b1; ack_i = 1'b1;
    for (int s = 0; s < 17; s++) step("R3");
    req_i = 1'b0;
    step("R3");
    check("R3", prio_o, lut_main_i[63:60]);

    // R1: no request, toggling ack leaves output unchanged
    len_sel_i = 4'd3; step("R1");
    for (int s = 0; s < 6; s++) begin
      ack_i = s[0];
      step("R1");
      check("R1", prio_o, lut_main_i[4*4 +: 4]);
    end

    // R6: threshold boundary with four ones in view
    tbl_mode_i = 1'b0;
    disp_prio_i = 4'd8; step("R6");
    check("R6", prio_o, lut_main_i[4*4 +: 4]);
    disp_prio_i = 4'd9; step("R6");
    check("R6", prio_o, lut_alt_i[4*4 +: 4]);

    // R5: congestion rule
    tbl_mode_i = 1'b1; cong_i = 1'b1; step("R5");
    check("R5", prio_o, lut_alt_i[4*4 +: 4]);

    // R8: override passes every value
    bypass_en_i = 1'b1;
    for (int v = 0; v < 16; v++) begin
      disp_prio_i = 4'(v);
      step("R8");
      check("R8", prio_o, 4'(v));
    end
    bypass_en_i = 1'b0;
    step("R8 release");

    // R7: a new history bit reaches the output two edges later
    len_sel_i = 4'd0; req_i = 1'b1; ack_i = 1'b0; cong_i = 1'b0;
    step("R7"); req_i = 1'b0; step("R7");
    check("R7", prio_o, lut_main_i[3:0]);
    req_i = 1'b1; ack_i = 1'b1; step("R7");
    req_i = 1'b0;
    check("R7", prio_o, lut_main_i[3:0]);
    step("R7");
    check("R7", prio_o, lut_main_i[7:4]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule